// File: doc/BRIEF.md
# Serial Register Port With Command Byte

This block is a synchronous serial slave. A host uses it to reach a small bank of 4-byte internal registers. The host's serial clock `sclk` clocks the whole block, and `sel_n` selects it (active low).

Each transaction has two parts:
- a command byte;
- a data phase of one to four bytes, either all read or all written.

The data can come back in two ways:
- **2-wire:** read data returns on the same line that carries commands. The pad is driven through `sdio_o` and `sdio_oe`.
- **3-wire:** read data leaves on a separate output, `sdo_o` with `sdo_oe`.

The enables go to pad buffers outside the block.

A control register sets two options for the data bytes:
- whether the byte address steps down or up;
- whether each byte is shifted MSB-first or LSB-first.

Raising the select in mid-transaction only pauses the transfer. A separate asynchronous interface reset puts the serial logic back to idle and leaves the registers alone. This reset is how a host that has lost its place gets back in step.

Top module: `ser_reg_port`

## Requirements
- R1: The command byte is always shifted MSB-first. Its fields are: bit 7 = 1 for a read; bits 6:5 = byte count minus one; bits 4:2 = register index; bits 1:0 = starting byte address.
- R2: One write transaction can load several bytes of one register, up to all four. A later read returns them.
- R3: With the direction bit at 0, each following byte address is one lower than the last. With the direction bit at 1, it is one higher. In both cases the address wraps modulo 4.
- R4: The control register is register index 0, byte 0. Its bit 1 is the direction bit (1 = ascending). Its bit 2 is the order bit (1 = LSB-first). The block samples both bits when the last command bit arrives and keeps those values for the whole data phase.
- R5: Inputs are sampled on the rising edge of `sclk`, and read bits change on the falling edge. The first read bit appears on the falling edge after the last command bit. In 3-wire mode only `sdo_oe` is asserted, and in 2-wire mode only `sdio_oe`.
- R6: No output enable is asserted while `sel_n` is high, during the command byte, or during a write.
- R7: While `sel_n` is high, the transaction holds its bit and byte position. It continues from that position when `sel_n` returns low.
- R8: After the last data byte the block is idle. The very next `sclk` bit is taken as the MSB of a new command.
- R9: Pulsing `ifc_rst_n` low aborts any transaction in progress. Register contents are unchanged, and a full transaction can start right after the pulse.
- R10: Index 6 and index 7 hold no register. A write to either is ignored, and a read from either returns zero bytes.
- R11: After `rst_n`, every register byte is zero and no output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Host serial clock |
| rst_n | input | 1 | Asynchronous full reset, active low |
| ifc_rst_n | input | 1 | Asynchronous reset of the serial logic only, active low |
| sel_n | input | 1 | Select, active low; high pauses the transaction |
| three_wire | input | 1 | 1 = read data on sdo_o, 0 = read data on the shared line |
| sdio_i | input | 1 | Serial input from the shared data pad |
| sdio_o | output | 1 | Read data toward the shared data pad |
| sdio_oe | output | 1 | Drive enable for the shared data pad |
| sdo_o | output | 1 | Read data toward the separate output pad |
| sdo_oe | output | 1 | Drive enable for the separate output pad |

## Verification
Each input bit takes effect at the rising edge that samples it. A byte that completes at a rising edge is therefore visible to any later transaction.

A read bit is set up on the falling edge half a cycle before the rising edge at which the host takes it. The bench drives inputs at falling edges and samples read data and enables 2 ns after each rising edge, when the bit is stable.

The enables follow `sel_n` without delay. Pause checks therefore sample during the deselected cycles, and each resumed bit is compared with the value that was due at that position.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  // Command layout is fixed by the protocol: 1 + 2 + 3 + 2 bits.
  localparam int IDX_W         = 3;
  localparam int ADDR_W        = 2;
  localparam int BYTES_PER_REG = 1 << ADDR_W;
  localparam int CTL_ASC_BIT   = 1;
  localparam int CTL_LSB_BIT   = 2;

  typedef struct packed {
    logic              rd;
    logic [1:0]        cnt_m1;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] start;
  } cmd_t;

  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;

  // Next byte address, wrapping inside the register.
  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic asc);
    return asc ? a + ADDR_W'(1) : a - ADDR_W'(1);
  endfunction

  // Accumulate one serial bit into a byte under the chosen bit order.
  function automatic logic [7:0] shift_in(logic [7:0] sh, logic b, logic lsb_first);
    return lsb_first ? {b, sh[7:1]} : {sh[6:0], b};
  endfunction

  // Bit of a byte that goes out at serial position k.
  function automatic logic pick_bit(logic [7:0] v, logic [2:0] k, logic lsb_first);
    return lsb_first ? v[k] : v[3'd7 - k];
  endfunction
endpackage

// File: rtl/ser_cmd_seq.sv
module ser_cmd_seq
  import ser_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              din,
  input  logic              ctl_asc,
  input  logic              ctl_lsb,
  output logic              in_data,
  output logic              is_read,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [2:0]        bit_pos,
  output logic              lsb_first,
  output logic              wr_en,
  output logic [7:0]        wr_data
);
  phase_e            phase_q;
  logic [2:0]        bit_q;
  logic [7:0]        sh_q;
  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        left_q;
  logic              asc_q, lsb_q;

  logic       adv, cmd_done, byte_done;
  logic [7:0] cmd_next;
  cmd_t       cmd_in;

  assign adv       = !sel_n;
  assign cmd_next  = {sh_q[6:0], din};
  assign cmd_in    = cmd_t'(cmd_next);
  assign wr_data   = shift_in(sh_q, din, lsb_q);
  assign cmd_done  = adv && (phase_q == PH_CMD)  && (bit_q == 3'd7);
  assign byte_done = adv && (phase_q == PH_DATA) && (bit_q == 3'd7);
  assign wr_en     = byte_done && !cmd_q.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      sh_q    <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      asc_q   <= 1'b0;
      lsb_q   <= 1'b0;
    end else if (adv) begin
      bit_q <= bit_q + 3'd1;
      if (phase_q == PH_CMD) begin
        sh_q <= cmd_next;
        if (cmd_done) begin
          cmd_q   <= cmd_in;
          addr_q  <= cmd_in.start;
          left_q  <= cmd_in.cnt_m1;
          asc_q   <= ctl_asc;
          lsb_q   <= ctl_lsb;
          phase_q <= PH_DATA;
        end
      end else begin
        sh_q <= wr_data;
        if (byte_done) begin
          if (left_q == 2'd0) begin
            phase_q <= PH_CMD;
          end else begin
            left_q <= left_q - 2'd1;
            addr_q <= step_addr(addr_q, asc_q);
          end
        end
      end
    end
  end

  assign in_data   = (phase_q == PH_DATA);
  assign is_read   = cmd_q.rd;
  assign reg_idx   = cmd_q.idx;
  assign byte_addr = addr_q;
  assign bit_pos   = bit_q;
  assign lsb_first = lsb_q;

  p_hold_when_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ($stable(bit_q) && $stable(phase_q) && $stable(addr_q) && $stable(left_q)));

  p_cmd_loads_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (phase_q == PH_DATA && bit_q == 3'd0 &&
                  left_q == $past(cmd_next[6:5]) && addr_q == $past(cmd_next[1:0])));

  p_addr_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && left_q != 2'd0) |=>
      (ADDR_W'(addr_q - $past(addr_q)) == ($past(asc_q) ? ADDR_W'(1) : ADDR_W'(3))));

  p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && left_q == 2'd0) |=> (phase_q == PH_CMD && bit_q == 3'd0));
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
  import ser_port_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              ctl_asc,
  output logic              ctl_lsb
);
  logic [7:0]          mem [NUM_REGS][BYTES_PER_REG];
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign hit[g] = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < BYTES_PER_REG; b++) mem[g][b] <= '0;
      end else if (hit[g]) begin
        mem[g][addr] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx == IDX_W'(r)) rd_data = mem[r][addr];
    end
  end

  assign ctl_asc = mem[0][0][CTL_ASC_BIT];
  assign ctl_lsb = mem[0][0][CTL_LSB_BIT];

  p_no_ghost_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(idx) >= NUM_REGS)) |-> (hit == '0));
endmodule

// File: rtl/ser_tx_out.sv
module ser_tx_out
  import ser_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_data,
  input  logic       is_read,
  input  logic [2:0] bit_pos,
  input  logic       lsb_first,
  input  logic [7:0] byte_val,
  output logic       drive,
  output logic       bit_out
);
  // Falling-edge launch: the bit is stable for the host's rising-edge sample.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive   <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      drive   <= in_data && is_read;
      bit_out <= (in_data && is_read) ? pick_bit(byte_val, bit_pos, lsb_first) : 1'b0;
    end
  end

  p_drive_only_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (in_data && is_read));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_port_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic ifc_rst_n,
  input  logic sel_n,
  input  logic three_wire,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe
);
  logic              seq_rst_n;
  logic              in_data, is_read, lsb_first, wr_en, ctl_asc, ctl_lsb;
  logic [IDX_W-1:0]  reg_idx;
  logic [ADDR_W-1:0] byte_addr;
  logic [2:0]        bit_pos;
  logic [7:0]        wr_data, rd_data;
  logic              drive, bit_out;

  assign seq_rst_n = rst_n & ifc_rst_n;

  ser_cmd_seq u_seq (
    .clk(sclk), .rst_n(seq_rst_n), .sel_n(sel_n), .din(sdio_i),
    .ctl_asc(ctl_asc), .ctl_lsb(ctl_lsb),
    .in_data(in_data), .is_read(is_read), .reg_idx(reg_idx),
    .byte_addr(byte_addr), .bit_pos(bit_pos), .lsb_first(lsb_first),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  ser_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(sclk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx),
    .addr(byte_addr), .wr_data(wr_data), .rd_data(rd_data),
    .ctl_asc(ctl_asc), .ctl_lsb(ctl_lsb)
  );

  ser_tx_out u_tx (
    .clk(sclk), .rst_n(seq_rst_n), .in_data(in_data), .is_read(is_read),
    .bit_pos(bit_pos), .lsb_first(lsb_first), .byte_val(rd_data),
    .drive(drive), .bit_out(bit_out)
  );

  assign sdio_o  = bit_out;
  assign sdo_o   = bit_out;
  assign sdio_oe = drive && !sel_n && !three_wire;
  assign sdo_oe  = drive && !sel_n && three_wire;

  p_single_driver_r5: assert property (@(posedge sclk) disable iff (!seq_rst_n)
    $onehot0({sdio_oe, sdo_oe}));
endmodule

// File: tb/ser_reg_port_tb_top.sv
`timescale 1ns/1ps
module ser_reg_port_tb_top;
  localparam int NREG = 6;

  logic sclk = 1'b0, rst_n = 1'b0, ifc_rst_n = 1'b1, sel_n = 1'b1;
  logic three_wire = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;

  always #4 sclk = ~sclk;

  ser_reg_port #(.NUM_REGS(NREG)) dut_i (
    .sclk(sclk), .rst_n(rst_n), .ifc_rst_n(ifc_rst_n), .sel_n(sel_n),
    .three_wire(three_wire), .sdio_i(sdio_i), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  int n_chk = 0, n_fail = 0;
  int wr_oe_bad = 0, rd_oe_bad = 0, pause_bad = 0;
  int bitnum = 0, pause_bit = -1;
  logic [7:0] mdl [8][4];
  logic asc_m = 1'b0, lsb_m = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_off();
    sel_n = 1'b1;
    repeat (3) begin
      @(posedge sclk); #2;
      if (sdio_oe || sdo_oe) pause_bad++;
      @(negedge sclk);
    end
    sel_n = 1'b0;
  endtask

  task automatic maybe_pause();
    if (bitnum == pause_bit) hold_off();
    bitnum++;
  endtask

  task automatic send_bit(input logic b);
    maybe_pause();
    sdio_i = b;
    @(posedge sclk); #2;
    if (sdio_oe || sdo_oe) wr_oe_bad++;
    @(negedge sclk);
  endtask

  task automatic recv_bit(output logic b);
    maybe_pause();
    @(posedge sclk); #2;
    b = three_wire ? sdo_o : sdio_o;
    if (!(three_wire ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe))) rd_oe_bad++;
    @(negedge sclk);
  endtask

  task automatic send_cmd(input logic rd, input int idx, input int start, input int cnt);
    logic [7:0] c;
    c = {rd, 2'(cnt - 1), 3'(idx), 2'(start)};
    sel_n = 1'b0;
    for (int k = 0; k < 8; k++) send_bit(c[7-k]);
  endtask

  task automatic do_write(input int idx, input int start, input int cnt, input logic [31:0] data);
    int a;
    logic [7:0] v;
    bitnum = 0;
    send_cmd(1'b0, idx, start, cnt);
    a = start;
    for (int i = 0; i < cnt; i++) begin
      v = data[8*i +: 8];
      for (int k = 0; k < 8; k++) send_bit(lsb_m ? v[k] : v[7-k]);
      if (idx < NREG) mdl[idx][a] = v;
      a = asc_m ? (a + 1) % 4 : (a + 3) % 4;
    end
    asc_m = mdl[0][0][1];
    lsb_m = mdl[0][0][2];
  endtask

  task automatic do_read(input int idx, input int start, input int cnt, output logic [31:0] got);
    logic [7:0] v;
    logic b;
    got = '0;
    bitnum = 0;
    send_cmd(1'b1, idx, start, cnt);
    for (int i = 0; i < cnt; i++) begin
      v = '0;
      for (int k = 0; k < 8; k++) begin
        recv_bit(b);
        if (lsb_m) v[k] = b; else v[7-k] = b;
      end
      got[8*i +: 8] = v;
    end
  endtask

  task automatic check_reg(input int idx, input logic three, input string req);
    logic [31:0] got;
    int a;
    three_wire = three;
    rd_oe_bad = 0;
    a = asc_m ? 0 : 3;
    do_read(idx, a, 4, got);
    for (int i = 0; i < 4; i++) begin
      chk(got[8*i +: 8] == mdl[idx][a], req, 32'(got[8*i +: 8]), 32'(mdl[idx][a]));
      a = asc_m ? (a + 1) % 4 : (a + 3) % 4;
    end
    chk(rd_oe_bad == 0, {req, " R5 enable routing"}, 32'(rd_oe_bad), 32'd0);
  endtask

  task automatic set_mode(input logic asc, input logic lsb);
    do_write(0, 0, 1, {24'd0, 5'd0, lsb, asc, 1'b0});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    logic [31:0] d;
    for (int r = 0; r < 8; r++) for (int b = 0; b < 4; b++) mdl[r][b] = '0;
    repeat (3) @(negedge sclk);
    chk(!sdio_oe && !sdo_oe, "R11 enables low in reset", {sdio_oe, sdo_oe}, 0);
    rst_n = 1'b1;
    @(negedge sclk);
    check_reg(1, 1'b1, "R11 zero after reset");
    check_reg(0, 1'b0, "R11 control zero after reset");

    do_write(1, 3, 4, 32'h11223344);
    check_reg(1, 1'b1, "R2 four-byte write");
    do_write(2, 1, 3, 32'h00C3B2A1);
    check_reg(2, 1'b0, "R3 descending wrap");

    for (int mode = 0; mode < 4; mode++) begin
      set_mode(mode[0], mode[1]);
      for (int idx = 1; idx < NREG; idx++)
        for (int st = 0; st < 4; st++)
          for (int cnt = 1; cnt <= 4; cnt++) begin
            d = {8'(mode*5 + st*13 + idx*19 + 4), 8'(idx*17 + cnt*41 + 3),
                 8'(st*29 + cnt*3 + 2), 8'(mode*61 + idx*7 + cnt*11 + 1)};
            do_write(idx, st, cnt, d);
            check_reg(idx, 1'((st + cnt) % 2), "R1/R3/R4/R8 sweep");
          end
    end
    chk(wr_oe_bad == 0, "R6 no drive in command or write", 32'(wr_oe_bad), 32'd0);

    set_mode(1'b0, 1'b0);
    do_write(0, 0, 2, {16'd0, 8'hA1, 8'h04});
    check_reg(0, 1'b1, "R4 order fixed at command end");
    check_reg(4, 1'b0, "R4 lsb-first descending read");

    do_write(6, 0, 4, 32'hDEADBEEF);
    do_write(7, 2, 3, 32'h00FFFFFF);
    check_reg(6, 1'b1, "R10 missing register reads zero");
    check_reg(7, 1'b0, "R10 missing register reads zero");
    check_reg(1, 1'b1, "R10 other register untouched");

    pause_bit = 12;
    do_write(3, 2, 2, 32'h00005AC3);
    pause_bit = 21;
    check_reg(3, 1'b1, "R7 pause mid-write and mid-read");
    pause_bit = 4;
    check_reg(5, 1'b0, "R7 pause mid-command");
    pause_bit = -1;
    chk(pause_bad == 0, "R6 no drive while deselected", 32'(pause_bad), 32'd0);

    bitnum = 0;
    send_cmd(1'b0, 1, 0, 4);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    ifc_rst_n = 1'b0;
    #1 ifc_rst_n = 1'b1;
    check_reg(1, 1'b1, "R9 interface reset keeps contents");
    do_write(2, 0, 1, 32'h0000007E);
    check_reg(2, 1'b0, "R9 transaction after interface reset");
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge sclk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule